// File: doc/BRIEF.md
# Bus Access Breakpoint Matcher

This block watches the start of every bus cycle and emits a one-clock breakpoint pulse when the cycle meets a set of conditions that software has programmed. The conditions cover four things: a 32-bit breakpoint address, the class of access, the transfer direction and the transfer size. The address compare can be widened to an aligned block of 2 KB, 8 KB or 32 KB. It can also be inverted, so the pulse fires on every address outside that block. A debugger uses the inverted form to single-step all code except its own region.

Software programs two registers through a simple write port and can read them back. The breakpoint address register sits at select 0 and the control register at select 1. The control register holds these fields:

- bit 0: valid
- bits 9:1: class enables, where bit 1+k enables class code k
- bits 11:10: direction. 00 = off, 01 = reads, 10 = writes, 11 = both.
- bits 14:12: size. 000 = any, 001 = byte, 010 = word, 011 = three-byte, 100 = long.
- bits 16:15: block. 00 = exact, 01 = 2 KB, 10 = 8 KB, 11 = 32 KB.
- bit 17: invert
- bit 18: slow-setup mode

Class codes run from 0 to 8. Codes 0 to 3 are user data, user program, supervisor data and supervisor program. Codes 4 to 8 are the DMA channels.

Top module: `bkpt_matcher`

## Requirements
- R1: While the control valid bit (bit 0) is clear, bkpt_o never asserts.
- R2: A cycle matches only if its class code is below 9 and control bit 1+code is set. Codes 9 to 15 never match.
- R3: Direction field bits 11:10 behave as follows. 00 never matches, 01 matches reads (bus_rd=1), 10 matches writes (bus_rd=0), and 11 matches both.
- R4: Size field bits 14:12 behave as follows. 000 matches any bus_size. A nonzero value matches only an equal bus_size, with 1 = byte, 2 = word, 3 = three-byte and 4 = long.
- R5: Block field bits 16:15 ignore address bits below 0, 11, 13 or 15 for codes 00, 01, 10 and 11 respectively.
- R6: When invert (bit 17) is set, the address term is true only when the address falls outside the exact address or block.
- R7: In normal mode, a qualifying cycle start drives bkpt_o high for exactly the one clock after the sampling edge.
- R8: Only cycles with bus_start high are compared. Later burst beats with bus_start low never produce a pulse.
- R9: With slow-setup (bit 18) set, the cycle fields are captured at the start edge and compared one clock later. The pulse therefore appears two clocks after the start edge, and later changes of the bus fields have no effect on it.
- R10: A match needs the address, class, direction and size terms to be true together. Invert changes only the address term.
- R11: Reset clears both registers, including valid, and holds bkpt_o low.
- R12: cfg_rdata returns the breakpoint address when cfg_sel=0. When cfg_sel=1 it returns the control register, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 address, 1 control |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_sel |
| bus_start | input | 1 | Marks the first beat of a bus cycle |
| bus_addr | input | 32 | Cycle address |
| bus_cls | input | 4 | Access class code |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_size | input | 3 | Transfer size code |
| bkpt_o | output | 1 | Registered breakpoint pulse |

## Verification
The bench uses the default parameters: a 32-bit address and block widths of 11, 13 and 15 bits. These values let directed addresses sit just inside and just outside each aligned block around 0x0001_2345. Both edges of every block size can therefore be checked, in both normal and inverted form. The nine-class default allows class 8 (the last one enabled) and code 9 (out of range) to be tested side by side.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int CLS_N = 9;
  localparam int CLS_W = 4;
  localparam int SIZE_W = 3;

  typedef struct packed {
    logic             slow;
    logic             inv;
    logic [1:0]       blk;
    logic [SIZE_W-1:0] size;
    logic [1:0]       dir;
    logic [CLS_N-1:0] cls_en;
    logic             valid;
  } bkpt_ctrl_t;

  localparam int CTRL_W = $bits(bkpt_ctrl_t);
endpackage

// File: rtl/bkpt_cfg_regs.sv
module bkpt_cfg_regs
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              sel,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] rdata,
  output logic [ADDR_W-1:0] bp_addr,
  output bkpt_ctrl_t        ctrl
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  bkpt_ctrl_t        ctrl_q, ctrl_d;
  logic              addr_en, ctrl_en;

  always_comb begin
    addr_en = we & ~sel;
    ctrl_en = we & sel;
    addr_d  = wdata;
    ctrl_d  = bkpt_ctrl_t'(wdata[CTRL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (addr_en) addr_q <= addr_d;
      if (ctrl_en) ctrl_q <= ctrl_d;
    end
  end

  assign bp_addr = addr_q;
  assign ctrl    = ctrl_q;
  assign rdata   = sel ? {{(ADDR_W-CTRL_W){1'b0}}, ctrl_q} : addr_q;
endmodule

// File: rtl/bkpt_cmp.sv
module bkpt_cmp
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BLK_A  = 11,
  parameter int BLK_B  = 13,
  parameter int BLK_C  = 15
) (
  input  bkpt_ctrl_t        ctrl,
  input  logic [ADDR_W-1:0] bp_addr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CLS_W-1:0]  cls,
  input  logic              rd,
  input  logic [SIZE_W-1:0] size,
  output logic              match
);
  logic [CLS_N-1:0]  cls_hit;
  logic [ADDR_W-1:0] mask;
  int unsigned       low;
  logic              addr_in, addr_ok, cls_ok, dir_ok, size_ok;

  for (genvar g = 0; g < CLS_N; g++) begin : g_cls
    assign cls_hit[g] = ctrl.cls_en[g] && (cls == CLS_W'(g));
  end

  always_comb begin
    unique case (ctrl.blk)
      2'd0:    low = 0;
      2'd1:    low = BLK_A;
      2'd2:    low = BLK_B;
      default: low = BLK_C;
    endcase
    mask    = {ADDR_W{1'b1}} << low;
    addr_in = ((addr ^ bp_addr) & mask) == '0;
    addr_ok = addr_in ^ ctrl.inv;
    cls_ok  = |cls_hit;
    dir_ok  = (ctrl.dir[0] & rd) | (ctrl.dir[1] & ~rd);
    size_ok = (ctrl.size == '0) || (ctrl.size == size);
    match   = ctrl.valid & addr_ok & cls_ok & dir_ok & size_ok;
  end
endmodule

// File: rtl/bkpt_pipe.sv
module bkpt_pipe
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow,
  input  logic              bus_start,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CLS_W-1:0]  bus_cls,
  input  logic              bus_rd,
  input  logic [SIZE_W-1:0] bus_size,
  output logic [ADDR_W-1:0] sel_addr,
  output logic [CLS_W-1:0]  sel_cls,
  output logic              sel_rd,
  output logic [SIZE_W-1:0] sel_size,
  input  logic              match,
  output logic              bkpt_o
);
  logic [ADDR_W-1:0] cap_addr_q;
  logic [CLS_W-1:0]  cap_cls_q;
  logic              cap_rd_q;
  logic [SIZE_W-1:0] cap_size_q;
  logic              cap_en, cap_vld_q, cap_vld_d;
  logic              trig, bkpt_q, bkpt_d;

  always_comb begin
    cap_en    = bus_start & slow;
    cap_vld_d = bus_start & slow;
    trig      = slow ? cap_vld_q : bus_start;
    sel_addr  = slow ? cap_addr_q : bus_addr;
    sel_cls   = slow ? cap_cls_q  : bus_cls;
    sel_rd    = slow ? cap_rd_q   : bus_rd;
    sel_size  = slow ? cap_size_q : bus_size;
    bkpt_d    = trig & match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr_q <= '0;
      cap_cls_q  <= '0;
      cap_rd_q   <= 1'b0;
      cap_size_q <= '0;
    end else if (cap_en) begin
      cap_addr_q <= bus_addr;
      cap_cls_q  <= bus_cls;
      cap_rd_q   <= bus_rd;
      cap_size_q <= bus_size;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_vld_q <= 1'b0;
      bkpt_q    <= 1'b0;
    end else begin
      cap_vld_q <= cap_vld_d;
      bkpt_q    <= bkpt_d;
    end
  end

  assign bkpt_o = bkpt_q;

  AST_PULSE_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    bkpt_o |-> ($past(bus_start) || $past(bus_start, 2))); // R8
  AST_CAPTURE_SLOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    cap_vld_q |-> $past(slow)); // R9
endmodule

// File: rtl/bkpt_matcher.sv
module bkpt_matcher
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BLK_A  = 11,
  parameter int BLK_B  = 13,
  parameter int BLK_C  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              bus_start,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CLS_W-1:0]  bus_cls,
  input  logic              bus_rd,
  input  logic [SIZE_W-1:0] bus_size,
  output logic              bkpt_o
);
  logic              rst_meta_q, rst_sync_q;
  logic [ADDR_W-1:0] bp_addr, sel_addr;
  bkpt_ctrl_t        ctrl;
  logic [CLS_W-1:0]  sel_cls;
  logic              sel_rd, match;
  logic [SIZE_W-1:0] sel_size;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  bkpt_cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_q), .we(cfg_we), .sel(cfg_sel),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .bp_addr(bp_addr), .ctrl(ctrl)
  );

  bkpt_pipe #(.ADDR_W(ADDR_W)) u_pipe (
    .clk(clk), .rst_n(rst_sync_q), .slow(ctrl.slow), .bus_start(bus_start),
    .bus_addr(bus_addr), .bus_cls(bus_cls), .bus_rd(bus_rd), .bus_size(bus_size),
    .sel_addr(sel_addr), .sel_cls(sel_cls), .sel_rd(sel_rd), .sel_size(sel_size),
    .match(match), .bkpt_o(bkpt_o)
  );

  bkpt_cmp #(.ADDR_W(ADDR_W), .BLK_A(BLK_A), .BLK_B(BLK_B), .BLK_C(BLK_C)) u_cmp (
    .ctrl(ctrl), .bp_addr(bp_addr), .addr(sel_addr), .cls(sel_cls),
    .rd(sel_rd), .size(sel_size), .match(match)
  );

  AST_NO_FIRE_INVALID: assert property (@(posedge clk) disable iff (!rst_sync_q)
    bkpt_o |-> $past(ctrl.valid)); // R1
  AST_CLASS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (bkpt_o && !$past(ctrl.slow)) |-> ($past(bus_cls) < CLS_W'(CLS_N))); // R2
  AST_DIR_NOT_OFF: assert property (@(posedge clk) disable iff (!rst_sync_q)
    bkpt_o |-> ($past(ctrl.dir) != 2'b00)); // R3
endmodule

// File: tb/bkpt_matcher_tb.sv
module bkpt_matcher_tb;
  typedef struct packed {
    logic [31:0] ctrl;
    logic [31:0] addr;
    logic [3:0]  cls;
    logic        rd;
    logic [2:0]  size;
    logic        exp;
  } vec_t;

  function automatic logic [31:0] mk(logic v, logic [8:0] en, logic [1:0] dir,
                                     logic [2:0] sz, logic [1:0] blk, logic inv, logic slow);
    return {13'b0, slow, inv, blk, sz, dir, en, v};
  endfunction

  localparam logic [31:0] BP = 32'h0001_2345;
  localparam int NV = 26;
  localparam vec_t VT [NV] = '{
    '{mk(1,9'h1FF,2'b11,3'd0,2'd0,0,0), BP,            4'd0, 1'b1, 3'd4, 1'b1}, // R7 exact hit
    '{mk(1,9'h1FF,2'b11,3'd0,2'd0,0,0), BP+1,          4'd0, 1'b1, 3'd4, 1'b0}, // R5 exact miss
    '{mk(0,9'h1FF,2'b11,3'd0,2'd0,0,0), BP,            4'd0, 1'b1, 3'd4, 1'b0}, // R1
    '{mk(1,9'h1FE,2'b11,3'd0,2'd0,0,0), BP,            4'd0, 1'b1, 3'd4, 1'b0}, // R2 class off
    '{mk(1,9'h100,2'b11,3'd0,2'd0,0,0), BP,            4'd8, 1'b1, 3'd4, 1'b1}, // R2 class 8
    '{mk(1,9'h1FF,2'b11,3'd0,2'd0,0,0), BP,            4'd9, 1'b1, 3'd4, 1'b0}, // R2 code 9
    '{mk(1,9'h1FF,2'b01,3'd0,2'd0,0,0), BP,            4'd1, 1'b0, 3'd4, 1'b0}, // R3 read-only vs write
    '{mk(1,9'h1FF,2'b10,3'd0,2'd0,0,0), BP,            4'd1, 1'b0, 3'd4, 1'b1}, // R3 write-only
    '{mk(1,9'h1FF,2'b00,3'd0,2'd0,0,0), BP,            4'd1, 1'b1, 3'd4, 1'b0}, // R3 off
    '{mk(1,9'h1FF,2'b11,3'd2,2'd0,0,0), BP,            4'd2, 1'b1, 3'd2, 1'b1}, // R4 word
    '{mk(1,9'h1FF,2'b11,3'd2,2'd0,0,0), BP,            4'd2, 1'b1, 3'd1, 1'b0}, // R4 word vs byte
    '{mk(1,9'h1FF,2'b11,3'd3,2'd0,0,0), BP,            4'd2, 1'b1, 3'd3, 1'b1}, // R4 three-byte
    '{mk(1,9'h1FF,2'b11,3'd0,2'd1,0,0), 32'h0001_2000, 4'd3, 1'b1, 3'd1, 1'b1}, // R5 2K low edge
    '{mk(1,9'h1FF,2'b11,3'd0,2'd1,0,0), 32'h0001_2800, 4'd3, 1'b1, 3'd1, 1'b0}, // R5 2K past
    '{mk(1,9'h1FF,2'b11,3'd0,2'd2,0,0), 32'h0001_3FFF, 4'd3, 1'b1, 3'd1, 1'b1}, // R5 8K top
    '{mk(1,9'h1FF,2'b11,3'd0,2'd2,0,0), 32'h0001_4000, 4'd3, 1'b1, 3'd1, 1'b0}, // R5 8K past
    '{mk(1,9'h1FF,2'b11,3'd0,2'd3,0,0), 32'h0001_7FFF, 4'd3, 1'b1, 3'd1, 1'b1}, // R5 32K top
    '{mk(1,9'h1FF,2'b11,3'd0,2'd3,0,0), 32'h0001_8000, 4'd3, 1'b1, 3'd1, 1'b0}, // R5 32K past
    '{mk(1,9'h1FF,2'b11,3'd0,2'd3,0,0), 32'h0000_FFFF, 4'd3, 1'b1, 3'd1, 1'b0}, // R5 32K below
    '{mk(1,9'h1FF,2'b11,3'd0,2'd0,1,0), BP,            4'd0, 1'b1, 3'd4, 1'b0}, // R6 inv exact hit
    '{mk(1,9'h1FF,2'b11,3'd0,2'd0,1,0), 32'h0040_0000, 4'd0, 1'b1, 3'd4, 1'b1}, // R6 inv outside
    '{mk(1,9'h1FF,2'b11,3'd0,2'd1,1,0), 32'h0001_27FF, 4'd0, 1'b1, 3'd4, 1'b0}, // R6 inv in block
    '{mk(1,9'h1FF,2'b11,3'd0,2'd1,1,0), 32'h0001_1FFF, 4'd0, 1'b1, 3'd4, 1'b1}, // R6 inv below block
    '{mk(1,9'h1FF,2'b01,3'd0,2'd0,1,0), 32'h0040_0000, 4'd0, 1'b0, 3'd4, 1'b0}, // R10 inv, dir fails
    '{mk(1,9'h1FE,2'b11,3'd0,2'd0,1,0), 32'h0040_0000, 4'd0, 1'b1, 3'd4, 1'b0}, // R10 inv, class fails
    '{mk(1,9'h1FF,2'b11,3'd4,2'd0,1,0), 32'h0040_0000, 4'd0, 1'b1, 3'd2, 1'b0}  // R10 inv, size fails
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_sel = 1'b0, bus_start = 1'b0, bus_rd = 1'b0;
  logic [31:0] cfg_wdata = '0, bus_addr = '0, cfg_rdata;
  logic [3:0] bus_cls = '0;
  logic [2:0] bus_size = '0;
  logic bkpt_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bkpt_matcher u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_start(bus_start),
    .bus_addr(bus_addr), .bus_cls(bus_cls), .bus_rd(bus_rd),
    .bus_size(bus_size), .bkpt_o(bkpt_o)
  );

  task automatic check(logic [31:0] got, logic [31:0] exp, string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic sel, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic start(logic [31:0] a, logic [3:0] c, logic r, logic [2:0] s);
    @(negedge clk);
    bus_start = 1'b1; bus_addr = a; bus_cls = c; bus_rd = r; bus_size = s;
    @(negedge clk);
    bus_start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({31'b0, bkpt_o}, 32'd0, "R11 bkpt low in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cfg_sel = 1'b1; #0.1;
    check(cfg_rdata, 32'd0, "R11 ctrl reset");
    cfg_sel = 1'b0; #0.1;
    check(cfg_rdata, 32'd0, "R11 addr reset");

    wr(1'b0, BP);
    cfg_sel = 1'b0; #0.1;
    check(cfg_rdata, BP, "R12 addr readback");
    for (int i = 0; i < NV; i++) begin
      wr(1'b1, VT[i].ctrl);
      cfg_sel = 1'b1; #0.1;
      check(cfg_rdata, VT[i].ctrl, "R12 ctrl readback");
      start(VT[i].addr, VT[i].cls, VT[i].rd, VT[i].size);
      check({31'b0, bkpt_o}, {31'b0, VT[i].exp}, $sformatf("R10 vector %0d", i));
      @(negedge clk);
      check({31'b0, bkpt_o}, 32'd0, "R7 pulse one clock");
    end

    // R8 burst: one start beat, then beats without start on the same address
    wr(1'b1, mk(1, 9'h1FF, 2'b11, 3'd0, 2'd0, 0, 0));
    start(BP, 4'd0, 1'b1, 3'd4);
    check({31'b0, bkpt_o}, 32'd1, "R8 first beat");
    for (int b = 0; b < 3; b++) begin
      @(negedge clk);
      check({31'b0, bkpt_o}, 32'd0, "R8 later beat ignored");
    end

    // R9 slow mode: two clocks of latency, captured fields
    wr(1'b1, mk(1, 9'h1FF, 2'b11, 3'd0, 2'd0, 0, 1));
    start(BP, 4'd0, 1'b1, 3'd4);
    bus_addr = 32'h0040_0000; bus_cls = 4'd9;
    check({31'b0, bkpt_o}, 32'd0, "R9 not after one clock");
    @(negedge clk);
    check({31'b0, bkpt_o}, 32'd1, "R9 fires after two clocks");
    @(negedge clk);
    check({31'b0, bkpt_o}, 32'd0, "R9 single pulse");
    start(32'h0040_0000, 4'd0, 1'b1, 3'd4);
    bus_addr = BP;
    @(negedge clk);
    check({31'b0, bkpt_o}, 32'd0, "R9 captured miss stays miss");

    // R11 reset mid-run clears valid
    wr(1'b1, mk(1, 9'h1FF, 2'b11, 3'd0, 2'd0, 0, 0));
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cfg_sel = 1'b1; #0.1;
    check(cfg_rdata, 32'd0, "R11 valid cleared by reset");
    start(32'h0, 4'd0, 1'b1, 3'd4);
    check({31'b0, bkpt_o}, 32'd0, "R1 no fire after reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule